// File: doc/BRIEF.md
# Adaptive Dead-Time Half-Bridge Gate Sequencer

This block turns a single PWM command into two complementary gate-enable signals for a half-bridge: one for the high-side switch and one for the low-side switch. When the command changes, the block removes the drive that is currently on. It then waits until the comparator feedback for that gate reports the gate below threshold. Only after that does it run a programmable dead-time counter, and the opposite drive is enabled when the counter finishes. Because the dead-time starts from the measured gate fall and not from the command edge, the guard interval adapts to the real turn-off speed of the switch.

Two undervoltage flags gate the outputs. The supply flag holds both drives off. The bootstrap flag holds only the high-side drive off, and the low side keeps working normally. All feedback and undervoltage inputs are asynchronous. They pass through two-flop synchronizers before use. After any lockout is released, a drive comes back only through the normal sense-then-count sequence.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: At the first clock edge that samples `pwm_in` high, the low-side drive is removed (`lo_out` is 0 after that edge), and `ho_out` stays 0 at that point.
- R2: The high-side dead-time count starts only at an edge where the synchronized `lo_sense` is 0. If that sense returns to 1 while counting, the count is abandoned and the sequencer waits again.
- R3: `ho_out` goes to 1 exactly `eff` clock edges after the edge that started the high-side count. Here `eff` is the effective dead-time in cycles.
- R4: A falling `pwm_in` removes `ho_out` on the first edge that samples it low. The low-side count starts only when the synchronized `ho_sense` is 0, and `lo_out` asserts `eff` edges later.
- R5: `ho_out` and `lo_out` are never 1 together. In steady state, PWM 0 gives LO=1 and HO=0, and PWM 1 gives LO=0 and HO=1.
- R6: The effective dead-time `eff` is `dt_count` in clock cycles. Any `dt_count` below `DT_MIN` (default 22) behaves as `DT_MIN`.
- R7: While the synchronized `uv_supply` is 1, both outputs are 0 whatever the PWM level.
- R8: While the synchronized `uv_boot` is 1, `ho_out` is 0, and `lo_out` still follows the PWM and dead-time sequence.
- R9: A PWM reversal during a pending dead-time cancels that count. The opposite transition then begins from the current gate-sense state.
- R10: `ho_sense`, `lo_sense`, `uv_supply` and `uv_boot` each pass through a two-flop synchronizer, so a change takes effect two edges later. Active-low synchronous reset forces both outputs to 0, and the synchronizers reset to "gate high, undervoltage present".
- R11: When a lockout releases, no output asserts at once. It asserts only after the opposite sense is seen low and a full dead-time elapses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_in | input | 1 | PWM command, 1 = high side on |
| ho_sense | input | 1 | Comparator: high-side gate above threshold (asynchronous) |
| lo_sense | input | 1 | Comparator: low-side gate above threshold (asynchronous) |
| dt_count | input | DT_W | Dead-time in clock cycles, clamped below at DT_MIN |
| uv_supply | input | 1 | Supply undervoltage flag (asynchronous) |
| uv_boot | input | 1 | Bootstrap undervoltage flag (asynchronous) |
| ho_out | output | 1 | High-side gate enable |
| lo_out | output | 1 | Low-side gate enable |

## Verification
The bench closes the loop with a small gate model that echoes each drive back onto its sense input two cycles late. Slow PWM toggles then check the full sense-then-count latency in both directions. A low `dt_count` shows whether the clamp is applied.

A sense input held stuck high shows whether the timer really waits for feedback rather than the edge. A PWM reversal in the middle of a count separates cancellation from completion.

Bootstrap and supply lockouts are each applied and released under both PWM levels. This tells asymmetric gating apart from global gating, and a delayed resume apart from an immediate one.

// File: rtl/hb_pkg.sv
// Shared types for the half-bridge sequencer.
package hb_pkg;
    // Sequencer phase: waiting for opposite gate low, counting dead-time, driving.
    typedef enum logic [1:0] {
        PH_WAIT  = 2'd0,
        PH_COUNT = 2'd1,
        PH_ON    = 2'd2
    } hb_phase_e;
endpackage

// File: rtl/hb_sync2.sv
// Two-flop synchronizer for a bundle of independent asynchronous flags.
// Assumes each bit is quasi-static relative to clk; no cross-bit coherence.
module hb_sync2 #(
    parameter int               W       = 4,
    parameter logic [W-1:0]     RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages; reset loads the safe value into both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/hb_dt_timer.sv
// Dead-time down-counter. A load captures max(dt_cfg, DT_MIN); last is high
// while one cycle remains. Assumes DT_MIN >= 1 and fits in DT_W bits.
module hb_dt_timer #(
    parameter int DT_W   = 6,
    parameter int DT_MIN = 22
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            abort,
    input  logic [DT_W-1:0] dt_cfg,
    output logic            last
);
    localparam logic [DT_W-1:0] MIN_V = DT_MIN[DT_W-1:0];

    logic [DT_W-1:0] cnt;
    logic [DT_W-1:0] eff;

    // Clamp the configured count up to the minimum.
    always_comb eff = (dt_cfg < MIN_V) ? MIN_V : dt_cfg;

    // Load, cancel or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (load)          cnt <= eff;
        else if (abort)         cnt <= '0;
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign last = (cnt == {{(DT_W-1){1'b0}}, 1'b1});

    // R6: a freshly loaded count is never below the minimum.
    a_r6_clamp_min: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt >= MIN_V));
endmodule

// File: rtl/hb_deadtime_ctrl.sv
// Half-bridge sequencer: one PWM command to two complementary gate enables
// with adaptive dead-time (count starts when the opposite gate is sensed low).
// Assumes pwm_in is synchronous to clk; sense and UVLO inputs are asynchronous.
module hb_deadtime_ctrl
    import hb_pkg::*;
#(
    parameter int DT_W   = 6,
    parameter int DT_MIN = 22
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwm_in,
    input  logic            ho_sense,
    input  logic            lo_sense,
    input  logic [DT_W-1:0] dt_count,
    input  logic            uv_supply,
    input  logic            uv_boot,
    output logic            ho_out,
    output logic            lo_out
);
    localparam int NSYNC = 4;

    logic [NSYNC-1:0] raw_in;
    logic [NSYNC-1:0] sync_q;
    logic             hs_s, ls_s, uvs_s, uvb_s;
    hb_phase_e        phase;
    logic             side_hi;
    logic             force_wait;
    logic             opp_low;
    logic             tmr_load;
    logic             tmr_abort;
    logic             tmr_last;

    assign raw_in = {uv_boot, uv_supply, lo_sense, ho_sense};

    hb_sync2 #(.W(NSYNC), .RST_VAL({NSYNC{1'b1}})) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_q)
    );

    assign hs_s  = sync_q[0];
    assign ls_s  = sync_q[1];
    assign uvs_s = sync_q[2];
    assign uvb_s = sync_q[3];

    // Conditions that drop the sequencer back to waiting and retarget its side.
    always_comb begin
        force_wait = uvs_s || (pwm_in != side_hi) || (side_hi && uvb_s);
        opp_low    = side_hi ? !ls_s : !hs_s;
        tmr_load   = !force_wait && (phase == PH_WAIT) && opp_low;
        tmr_abort  = force_wait || ((phase == PH_COUNT) && !opp_low);
    end

    hb_dt_timer #(.DT_W(DT_W), .DT_MIN(DT_MIN)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .abort  (tmr_abort),
        .dt_cfg (dt_count),
        .last   (tmr_last)
    );

    // Phase sequencing: wait for opposite gate low, count, then drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_WAIT;
            side_hi <= 1'b0;
        end else if (force_wait) begin
            phase   <= PH_WAIT;
            side_hi <= pwm_in;
        end else begin
            unique case (phase)
                PH_WAIT:  if (opp_low) phase <= PH_COUNT;
                PH_COUNT: if (!opp_low)     phase <= PH_WAIT;
                          else if (tmr_last) phase <= PH_ON;
                PH_ON:    phase <= PH_ON;
                default:  phase <= PH_WAIT;
            endcase
        end
    end

    // Output gating: supply lockout kills both, bootstrap lockout only the high side.
    always_comb begin
        ho_out = (phase == PH_ON) &&  side_hi && !uvs_s && !uvb_s;
        lo_out = (phase == PH_ON) && !side_hi && !uvs_s;
    end

    // R5: the two drives never overlap.
    a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ho_out && lo_out));
    // R1: a high PWM sample removes the low drive after the edge.
    a_r1_rise_lo_off: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_in |=> !lo_out);
    // R4: a low PWM sample removes the high drive after the edge.
    a_r4_fall_ho_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_in |=> !ho_out);
    // R2: the high drive turns on only after the low gate was sensed low.
    a_r2_ho_after_lo_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ho_out) |-> !$past(ls_s));
    // R4: the low drive turns on only after the high gate was sensed low.
    a_r4_lo_after_ho_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_out) |-> !$past(hs_s));
    // R11: release of supply lockout never asserts a drive at once.
    a_r11_no_instant_resume: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(uvs_s) |-> (!ho_out && !lo_out));
endmodule

// File: tb/hb_deadtime_ctrl_test.sv
// Bench: behavioural cycle reference with a delayed gate feedback model.
module hb_deadtime_ctrl_test;
    localparam int DT_W   = 6;
    localparam int DT_MIN = 22;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pwm_in = 1'b0;
    logic            ho_sense = 1'b1;
    logic            lo_sense = 1'b1;
    logic [DT_W-1:0] dt_count = 6'd30;
    logic            uv_supply = 1'b1;
    logic            uv_boot = 1'b1;
    logic            ho_out, lo_out;

    always #2 clk = ~clk;   // 250 MHz

    hb_deadtime_ctrl #(.DT_W(DT_W), .DT_MIN(DT_MIN)) uut (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .ho_sense(ho_sense),
        .lo_sense(lo_sense), .dt_count(dt_count), .uv_supply(uv_supply),
        .uv_boot(uv_boot), .ho_out(ho_out), .lo_out(lo_out));

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 0;
    string cur_req = "R10";

    // Reference model state.
    int m_phase;          // 0 waiting, 1 counting, 2 driving
    bit m_hi;
    int m_left;
    bit q_hs[$], q_ls[$], q_uvs[$], q_uvb[$];
    bit m_ho = 0, m_lo = 0;

    // Gate feedback model.
    bit ho_hist[2] = '{0, 0};
    bit lo_hist[2] = '{0, 0};
    bit stuck_lo = 0, stuck_ho = 0;

    // Reference update on each rising edge from the requirements.
    always @(posedge clk) begin
        bit hs, ls, uvs, uvb, opp;
        int eff;
        if (!rst_n) begin
            m_phase = 0; m_hi = 0; m_left = 0;
            q_hs = '{1, 1}; q_ls = '{1, 1}; q_uvs = '{1, 1}; q_uvb = '{1, 1};
        end else begin
            hs = q_hs[0]; ls = q_ls[0]; uvs = q_uvs[0]; uvb = q_uvb[0];
            eff = (int'(dt_count) < DT_MIN) ? DT_MIN : int'(dt_count);
            opp = m_hi ? !ls : !hs;
            if (uvs || (pwm_in != m_hi) || (m_hi && uvb)) begin
                m_phase = 0; m_hi = pwm_in;
            end else if (m_phase == 0) begin
                if (opp) begin m_phase = 1; m_left = eff; end
            end else if (m_phase == 1) begin
                if (!opp) m_phase = 0;
                else if (m_left <= 1) m_phase = 2;
                else m_left--;
            end
            void'(q_hs.pop_front());  q_hs.push_back(ho_sense);
            void'(q_ls.pop_front());  q_ls.push_back(lo_sense);
            void'(q_uvs.pop_front()); q_uvs.push_back(uv_supply);
            void'(q_uvb.pop_front()); q_uvb.push_back(uv_boot);
        end
        m_ho = (m_phase == 2) &&  m_hi && !q_uvs[0] && !q_uvb[0];
        m_lo = (m_phase == 2) && !m_hi && !q_uvs[0];
    end

    // Generic check with failure report.
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cycles, act, exp);
        end
    endtask

    // One cycle: compare against the reference, then update gate feedback.
    task automatic step();
        @(negedge clk);
        chk({ho_out, lo_out} === {m_ho, m_lo}, cur_req, {ho_out, lo_out}, {m_ho, m_lo});
        chk(!(ho_out && lo_out), "R5", {ho_out, lo_out}, 0);
        ho_hist[1] = ho_hist[0]; ho_hist[0] = ho_out;
        lo_hist[1] = lo_hist[0]; lo_hist[0] = lo_out;
        ho_sense = ho_hist[1] | stuck_ho;
        lo_sense = lo_hist[1] | stuck_lo;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 20000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R10: reset holds both outputs low.
        cur_req = "R10";
        run(4);
        chk(ho_out == 0 && lo_out == 0, "R10", {ho_out, lo_out}, 0);
        @(negedge clk);
        rst_n = 1; uv_supply = 0; uv_boot = 0; pwm_in = 0;
        run(3);
        chk(lo_out == 0, "R10", lo_out, 0);   // synchronizer latency, no instant drive
        cur_req = "R4";
        run(50);
        chk(lo_out == 1 && ho_out == 0, "R5", {ho_out, lo_out}, 1);

        // R1, R2, R3: rising PWM, adaptive high-side turn-on.
        cur_req = "R3";
        pwm_in = 1;
        step();
        chk(lo_out == 0 && ho_out == 0, "R1", {ho_out, lo_out}, 0);
        run(60);
        chk(ho_out == 1 && lo_out == 0, "R3", {ho_out, lo_out}, 2);

        // R4: falling PWM, low-side turn-on after high gate sensed low.
        cur_req = "R4";
        pwm_in = 0;
        step();
        chk(ho_out == 0, "R4", ho_out, 0);
        run(60);
        chk(lo_out == 1, "R4", lo_out, 1);

        // R6: count below the minimum is clamped; latency measured directly.
        cur_req = "R6";
        dt_count = 6'd5;
        pwm_in = 1;
        begin
            int lat = 0;
            step();
            while (!ho_out && lat < 100) begin step(); lat++; end
            // 2 gate-model cycles + 2 sync edges + start edge + DT_MIN edges, less the first step
            chk(lat == DT_MIN + 4, "R6", lat, DT_MIN + 4);
        end
        dt_count = 6'd40;
        pwm_in = 0;
        run(70);

        // R2: low gate sensed stuck high blocks the high-side count.
        cur_req = "R2";
        stuck_lo = 1;
        pwm_in = 1;
        run(80);
        chk(ho_out == 0, "R2", ho_out, 0);
        stuck_lo = 0;
        run(60);
        chk(ho_out == 1, "R2", ho_out, 1);

        // R9: reversal during pending count cancels it.
        cur_req = "R9";
        pwm_in = 0;
        run(15);
        pwm_in = 1;
        run(4);
        chk(ho_out == 0 && lo_out == 0, "R9", {ho_out, lo_out}, 0);
        run(60);
        chk(ho_out == 1, "R9", ho_out, 1);

        // R8: bootstrap lockout hits only the high side.
        cur_req = "R8";
        uv_boot = 1;
        run(3);
        chk(ho_out == 0, "R8", ho_out, 0);
        pwm_in = 0;
        run(60);
        chk(lo_out == 1, "R8", lo_out, 1);
        pwm_in = 1;
        run(60);
        chk(ho_out == 0 && lo_out == 0, "R8", {ho_out, lo_out}, 0);

        // R11: bootstrap release resumes through sense and full dead-time.
        cur_req = "R11";
        uv_boot = 0;
        run(10);
        chk(ho_out == 0, "R11", ho_out, 0);
        run(60);
        chk(ho_out == 1, "R11", ho_out, 1);

        // R7: supply lockout forces both low for either PWM level.
        cur_req = "R7";
        uv_supply = 1;
        run(3);
        chk(ho_out == 0 && lo_out == 0, "R7", {ho_out, lo_out}, 0);
        pwm_in = 0;
        run(40);
        chk(ho_out == 0 && lo_out == 0, "R7", {ho_out, lo_out}, 0);

        // R11: supply release with a delayed low-side resume.
        cur_req = "R11";
        uv_supply = 0;
        run(8);
        chk(lo_out == 0, "R11", lo_out, 0);
        run(60);
        chk(lo_out == 1, "R11", lo_out, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule